// File: doc/BRIEF.md
# Output Override and Inversion Stage

This block conditions a row of board-level control pins. For each of eight outputs (battery disable, embedded-controller reset, power-button out, three key outputs, a wakeup line and flash write-protect) it takes the functional value produced elsewhere on the chip. It can replace that value with a software override and can then invert the result. Each input pin can be inverted on its way into the chip's logic. A registered copy of the raw input pins, taken before inversion, can be read back by software.

Software controls the stage through a small register port with one write strobe and a combinational read mux. An override reaches the pin only when two things hold: the pin's override enable is set, and the specific level being forced (0 or 1) has been separately authorized in an allow mask. A one-shot lock bit freezes the allow mask and the invert mask once software clears it. The override enable and override value stay writable after that.

Top module: `pin_cond_stage`

## Requirements
- R1: After reset the lock bit reads 1, the allow mask reads 0x0082, the override enable reads 0x82, the override value and invert masks read 0. Pins 1 (controller reset) and 7 (write-protect) are therefore driven 0 and all other outputs follow their functional value.
- R2: Output pin i carries the override value only when override enable bit i is set and that value is allowed for pin i. Otherwise it carries the functional value.
- R3: In the allow mask, bit i permits an override to 0 on output pin i and bit 8+i permits an override to 1 on the same pin. Output pin order is 0 battery disable, 1 controller reset, 2 power-button out, 3..5 keys 0..2, 6 wakeup, 7 write-protect.
- R4: Invert-mask bit 8+i inverts output pin i after the override selection, so a forced value is inverted as well.
- R5: Invert-mask bit i inverts input pin i. The conditioned input equals the raw input XOR that bit.
- R6: Register address 5 returns the input pins as sampled on the previous clock edge, before any inversion.
- R7: The lock bit (address 0, bit 0) is cleared by writing 0 there. Writing 1 never sets it again before the next reset.
- R8: While the lock bit is 0, writes to the allow mask (address 1) and the invert mask (address 2) leave them unchanged.
- R9: Override enable (address 3) and override value (address 4) accept writes whether or not the lock bit is set.
- R10: Each register reads back the last value it accepted, and writes to it take effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| func_out | input | 8 | Functional output values from chip logic |
| pin_out | output | 8 | Conditioned output pin values |
| pin_in | input | 8 | Raw input pin values |
| cond_in | output | 8 | Inputs after per-pin inversion |

## Verification
Assertions check on every cycle that the lock never comes back once cleared, that the allow and invert masks hold still while locked, that override registers accept writes under lock, and that a lane with override and inversion both off passes its functional value. Only the bench's scenarios can show the exact mapping of allow bits to pins and levels, that an unauthorized level is refused, and the order of override and output inversion. The same holds for the reset-time values and the raw readback being independent of input inversion.

// File: rtl/pcond_pkg.sv
// Shared register addresses for the pin conditioning stage.
// Assumes a 3-bit register address space.
package pcond_pkg;
    localparam int unsigned ADDR_W    = 3;
    localparam logic [ADDR_W-1:0] A_LOCK   = 3'd0;
    localparam logic [ADDR_W-1:0] A_ALLOW  = 3'd1;
    localparam logic [ADDR_W-1:0] A_INVERT = 3'd2;
    localparam logic [ADDR_W-1:0] A_OVR_EN = 3'd3;
    localparam logic [ADDR_W-1:0] A_OVR_VAL = 3'd4;
    localparam logic [ADDR_W-1:0] A_RAW_IN = 3'd5;
endpackage

// File: rtl/pcond_cfg_regs.sv
// Configuration registers: lock bit, allow mask, invert mask, override
// enable and override value, plus the read mux.
// Assumes: allow and invert are frozen while the lock bit is 0; the
// lock can only be cleared by software, never set again.
module pcond_cfg_regs
    import pcond_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter logic [2*N-1:0] ALLOW_RST = '0,
    parameter logic [N-1:0]   OVR_EN_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2*N-1:0]    wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N-1:0]      raw_sample,
    output logic [2*N-1:0]    rd_data,
    output logic [2*N-1:0]    allow_q,
    output logic [2*N-1:0]    inv_q,
    output logic [N-1:0]      ovr_en_q,
    output logic [N-1:0]      ovr_val_q
);
    localparam int unsigned DW = 2 * N;

    logic lock_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data[DW-1:N];

    // Register updates, with the lock gating the frozen pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q    <= 1'b1;
            allow_q   <= ALLOW_RST;
            inv_q     <= '0;
            ovr_en_q  <= OVR_EN_RST;
            ovr_val_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_LOCK:    if (!wr_data[0]) lock_q <= 1'b0;
                A_ALLOW:   if (lock_q) allow_q <= wr_data;
                A_INVERT:  if (lock_q) inv_q <= wr_data;
                A_OVR_EN:  ovr_en_q <= wr_data[N-1:0];
                A_OVR_VAL: ovr_val_q <= wr_data[N-1:0];
                default:   ;
            endcase
        end
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_LOCK:    rd_data[0] = lock_q;
            A_ALLOW:   rd_data = allow_q;
            A_INVERT:  rd_data = inv_q;
            A_OVR_EN:  rd_data[N-1:0] = ovr_en_q;
            A_OVR_VAL: rd_data[N-1:0] = ovr_val_q;
            A_RAW_IN:  rd_data[N-1:0] = raw_sample;
            default:   rd_data = '0;
        endcase
    end

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> !lock_q);
    a_r8_allow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> $stable(allow_q));
    a_r8_invert_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> $stable(inv_q));
    a_r9_ovr_en_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OVR_EN) |=> ovr_en_q == $past(wr_data[N-1:0]));
    a_r9_ovr_val_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OVR_VAL) |=> ovr_val_q == $past(wr_data[N-1:0]));
endmodule

// File: rtl/pcond_out_lane.sv
// One output lane: override selection gated by the per-level allow bits,
// followed by output inversion.
// Assumes all control inputs come from registers in the same clock domain.
module pcond_out_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic func,
    input  logic ovr_en,
    input  logic ovr_val,
    input  logic allow_lo,
    input  logic allow_hi,
    input  logic inv_out,
    output logic pin
);
    logic level_ok;
    logic selected;

    // Pick the override only when its level is authorized.
    always_comb begin
        level_ok = ovr_val ? allow_hi : allow_lo;
        selected = (ovr_en && level_ok) ? ovr_val : func;
        pin      = selected ^ inv_out;
    end

    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en && !inv_out) |-> pin == func);
    a_r2_refused_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!allow_lo && !allow_hi && !inv_out) |-> pin == func);
endmodule

// File: rtl/pcond_in_lane.sv
// Input conditioning: per-pin inversion toward chip logic, plus a raw
// sample register (before inversion) for software readback.
// Assumes input pins are already synchronized to clk.
module pcond_in_lane #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    input  logic [N-1:0] inv_in,
    output logic [N-1:0] cond_in,
    output logic [N-1:0] raw_q
);
    // Capture raw pin levels for readback.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= pin_in;
    end

    // Invert inputs as configured.
    always_comb cond_in = pin_in ^ inv_in;

    a_r5_no_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_in == '0) |-> cond_in == pin_in);
endmodule

// File: rtl/pin_cond_stage.sv
// Top of the output override and inversion stage. Wires the register
// file, one output lane per pin and the input conditioning.
// Assumes a single clock domain and synchronous active-low reset.
module pin_cond_stage
    import pcond_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2*N-1:0]    wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [2*N-1:0]    rd_data,
    input  logic [N-1:0]      func_out,
    output logic [N-1:0]      pin_out,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      cond_in
);
    localparam logic [N-1:0]   RST_PINS  = N'(8'h82);
    localparam logic [2*N-1:0] ALLOW_RST = {{N{1'b0}}, RST_PINS};

    logic [2*N-1:0] allow_q;
    logic [2*N-1:0] inv_q;
    logic [N-1:0]   ovr_en_q;
    logic [N-1:0]   ovr_val_q;
    logic [N-1:0]   raw_q;

    pcond_cfg_regs #(
        .N(N), .ALLOW_RST(ALLOW_RST), .OVR_EN_RST(RST_PINS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .raw_sample(raw_q),
        .rd_data(rd_data), .allow_q(allow_q), .inv_q(inv_q),
        .ovr_en_q(ovr_en_q), .ovr_val_q(ovr_val_q)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        pcond_out_lane u_lane (
            .clk(clk), .rst_n(rst_n), .func(func_out[i]),
            .ovr_en(ovr_en_q[i]), .ovr_val(ovr_val_q[i]),
            .allow_lo(allow_q[i]), .allow_hi(allow_q[N+i]),
            .inv_out(inv_q[N+i]), .pin(pin_out[i])
        );
    end

    pcond_in_lane #(.N(N)) u_in (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .inv_in(inv_q[N-1:0]),
        .cond_in(cond_in), .raw_q(raw_q)
    );
endmodule

// File: tb/pin_cond_stage_bench.sv
module pin_cond_stage_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  func_out = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_in = '0;
    logic [7:0]  cond_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pin_cond_stage u_pin_cond_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .func_out(func_out), .pin_out(pin_out), .pin_in(pin_in),
        .cond_in(cond_in)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic pins_check(input string req, input logic [7:0] f, input logic [7:0] exp);
        func_out = f;
        #1;
        check(req, {8'h00, pin_out}, {8'h00, exp});
    endtask

    task automatic t_reset;
        rd_check("R1 lock", 3'd0, 16'h0001);
        rd_check("R1 allow", 3'd1, 16'h0082);
        rd_check("R1 invert", 3'd2, 16'h0000);
        rd_check("R1 ovr_en", 3'd3, 16'h0082);
        rd_check("R1 ovr_val", 3'd4, 16'h0000);
        pins_check("R1 pins func=ff", 8'hFF, 8'h7D);
        pins_check("R1 pins func=00", 8'h00, 8'h00);
    endtask

    task automatic t_override_gate;
        // R2: enable pin 0, force 1, but only allow-0 granted -> passthrough
        wr(3'd3, 16'h0001);
        wr(3'd4, 16'h0001);
        wr(3'd1, 16'h0001);
        pins_check("R2 level not allowed", 8'h00, 8'h00);
        // R3: grant allow-1 on pin 0 (bit 8) -> forced to 1
        wr(3'd1, 16'h0100);
        pins_check("R3 allow-1 pin0", 8'h00, 8'h01);
        // R2: value 0 with only allow-1 -> refused, func passes
        wr(3'd4, 16'h0000);
        pins_check("R2 zero refused", 8'h01, 8'h01);
        // R2: enable cleared, value allowed -> passthrough
        wr(3'd1, 16'h0101);
        wr(3'd3, 16'h0000);
        pins_check("R2 enable off", 8'h5A, 8'h5A);
    endtask

    task automatic t_layout;
        // R3: pin 3 allow-1 is bit 11; others follow func
        wr(3'd1, 16'h0800);
        wr(3'd3, 16'h0008);
        wr(3'd4, 16'h0008);
        pins_check("R3 pin3 forced 1", 8'h00, 8'h08);
        pins_check("R3 pin3 others follow", 8'hF0, 8'hF8);
        // R3: pin 7 allow-0 is bit 7
        wr(3'd1, 16'h0080);
        wr(3'd3, 16'h0080);
        wr(3'd4, 16'h0000);
        pins_check("R3 pin7 forced 0", 8'hFF, 8'h7F);
    endtask

    task automatic t_invert;
        // R4: pin 7 forced 0, then output-inverted (bit 15) -> 1; pin 2 inverted
        wr(3'd2, 16'h8400);
        pins_check("R4 invert after override", 8'h00, 8'h84);
        pins_check("R4 invert functional", 8'h04, 8'h80);
        // R5: invert inputs 0 and 5
        wr(3'd2, 16'h0021);
        pin_in = 8'h0F;
        #1;
        check("R5 cond_in", {8'h00, cond_in}, 16'h002E);
        // R6: raw readback one edge later, not inverted
        @(negedge clk);
        rd_check("R6 raw readback", 3'd5, 16'h000F);
        pin_in = 8'hA0;
        #1;
        rd_check("R6 raw before edge", 3'd5, 16'h000F);
        @(negedge clk);
        rd_check("R6 raw after edge", 3'd5, 16'h00A0);
    endtask

    task automatic t_lock;
        wr(3'd0, 16'h0000);
        rd_check("R7 lock cleared", 3'd0, 16'h0000);
        wr(3'd0, 16'h0001);
        rd_check("R7 lock stays clear", 3'd0, 16'h0000);
        wr(3'd1, 16'hFFFF);
        rd_check("R8 allow frozen", 3'd1, 16'h0080);
        wr(3'd2, 16'hFF00);
        rd_check("R8 invert frozen", 3'd2, 16'h0021);
        pins_check("R8 pins unchanged", 8'h00, 8'h00);
        wr(3'd3, 16'h0081);
        rd_check("R9 ovr_en writable", 3'd3, 16'h0081);
        wr(3'd4, 16'h0001);
        rd_check("R10 ovr_val readback", 3'd4, 16'h0001);
        // pin 0 wants 1 but allow-1 not granted; pin 7 forced 0
        pins_check("R9 effect under lock", 8'hFF, 8'h7F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_override_gate();
        t_layout();
        t_invert();
        t_lock();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule